// File: doc/BRIEF.md
# USB Low/Full-Speed Line Receiver

This block turns an oversampled pair of USB data lines into the decoded packet bitstream of a low-speed or full-speed link. Every clock it classifies the two line levels into one of four line states and presents that state on `sym_o`. When an idle line moves from J to K it starts a packet and sets up a fixed sampling grid. The grid is anchored on that edge and is not moved again.

At each grid point the block NRZI-decodes the line state and removes the zero that a transmitter inserts after six ones. It reports each data bit on a one-cycle strobe. A single-ended zero at a grid point begins the end-of-packet sequence, which completes when a J follows a sampled SE0. An SE1 during the data phase aborts the packet with an error pulse. A speed input selects the clocks-per-bit count and inverts the J/K polarity for low speed.

Top module: `usb_line_rx`

## Requirements
- R1: `sym_o` reports the current line state combinationally with the encoding 2'b00 = SE0 (both lines low), 2'b01 = J, 2'b10 = K, 2'b11 = SE1 (both lines high). At full speed J is dp high with dm low, and K is the reverse.
- R2: With `low_speed_i` high, the J and K assignments of the differential states are swapped: dp low with dm high is J. SE0 and SE1 do not depend on speed.
- R3: While idle, a line state of K in a cycle whose previous line state was J starts a packet, and `sop_o` pulses for one cycle on the next clock.
- R4: The first grid point lies CPB/2 clocks after the start edge, and each later one follows CPB clocks after the one before. CPB is `CPB_FS` or `CPB_LS` according to speed. Bit and stuff strobes therefore appear CPB/2 cycles after `sop_o`, and then every CPB cycles.
- R5: At a grid point a J or K decodes to 1 when it equals the previous sampled data symbol and to 0 when it differs. The reference at the start of a packet is J.
- R6: A 0 decoded when exactly six 1s precede it in a row is a stuff bit. It raises `stuff_o` instead of `bit_valid_o` and clears the run of ones.
- R7: Every other decoded bit raises `bit_valid_o` for one cycle with the value on `bit_o`. A 0 clears the ones run and a 1 extends it. SE0, SE1 and the J that ends a packet produce no data strobe.
- R8: An SE0 at a grid point ends the data phase. `eop_o` pulses once when a J is sampled directly after a sampled SE0. The block then returns to idle with the decode state cleared.
- R9: An SE1 at a grid point during the data phase pulses `err_o`, produces no `eop_o` and returns the block to idle.
- R10: While `rst_ni` is low all strobes (`sop_o`, `bit_valid_o`, `bit_o`, `stuff_o`, `eop_o`, `err_o`) are low.
- R11: In idle, a line held at J or SE0, or a change between them, produces no strobe of any kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | D+ line level, already synchronous |
| dm_i | input | 1 | D- line level, already synchronous |
| low_speed_i | input | 1 | 1 selects low speed, 0 selects full speed |
| sym_o | output | 2 | Current line state |
| sop_o | output | 1 | Start-of-packet pulse |
| bit_valid_o | output | 1 | Data bit strobe |
| bit_o | output | 1 | Decoded data bit, valid with bit_valid_o |
| stuff_o | output | 1 | Removed stuff bit strobe |
| eop_o | output | 1 | End-of-packet pulse |
| err_o | output | 1 | SE1 seen during the data phase |

## Verification
The timing assertions compare strobe spacing against the CPB of the current `low_speed_i`. They therefore assume that the speed input changes only while the block is idle. The bench changes speed only after parking the line at SE0, so the change cannot look like a J-to-K edge. The line levels are assumed to hold for whole bit times with no drift. The bench drives each symbol for exactly CPB clocks from the clock's inactive edge, and computes NRZI coding and stuffing itself for every byte of a full-speed sweep and for a low-speed subset.

// File: rtl/usb_line_pkg.sv
package usb_line_pkg;
  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_J   = 2'b01,
    SYM_K   = 2'b10,
    SYM_SE1 = 2'b11
  } line_sym_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BITS = 2'd1,
    ST_EOP  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/usb_sym_decode.sv
module usb_sym_decode
  import usb_line_pkg::*;
(
  input  logic      dp_i,
  input  logic      dm_i,
  input  logic      low_speed_i,
  output line_sym_e sym_o
);
  logic j_level;

  // low speed swaps the differential polarity
  assign j_level = low_speed_i ? dm_i : dp_i;

  always_comb begin
    if (dp_i == dm_i) sym_o = dp_i ? SYM_SE1 : SYM_SE0;
    else              sym_o = j_level ? SYM_J : SYM_K;
  end
endmodule

// File: rtl/usb_bit_timer.sv
module usb_bit_timer #(
  parameter int CPB_FS = 4,
  parameter int CPB_LS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_speed_i,
  input  logic start_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CPB_MAX = (CPB_LS > CPB_FS) ? CPB_LS : CPB_FS;
  localparam int CNT_W   = $clog2(CPB_MAX) + 1;
  localparam int HALF_FS = CPB_FS / 2;
  localparam int HALF_LS = CPB_LS / 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_ld, full_ld;

  assign half_ld = low_speed_i ? CNT_W'(HALF_LS - 1) : CNT_W'(HALF_FS - 1);
  assign full_ld = low_speed_i ? CNT_W'(CPB_LS - 1)  : CNT_W'(CPB_FS - 1);
  assign tick_o  = run_i && !start_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= half_ld;
    else if (run_i) begin
      if (cnt_q == '0)       cnt_q <= full_ld;
      else                   cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/usb_nrzi_destuff.sv
module usb_nrzi_destuff
  import usb_line_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clear_i,
  input  logic      sample_i,
  input  line_sym_e sym_i,
  output logic      data_vld_o,
  output logic      data_o,
  output logic      stuff_o
);
  localparam int ONES_W = $clog2(STUFF_RUN + 2);
  localparam logic [ONES_W-1:0] ONES_MAX = ONES_W'(STUFF_RUN + 1);

  line_sym_e         ref_q;
  logic [ONES_W-1:0] ones_q;
  logic              same, is_stuff;

  assign same       = (sym_i == ref_q);
  assign is_stuff   = (ones_q == ONES_W'(STUFF_RUN)) && !same;
  assign data_vld_o = sample_i && !is_stuff;
  assign data_o     = same;
  assign stuff_o    = sample_i && is_stuff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= SYM_J;
      ones_q <= '0;
    end else if (clear_i) begin
      ref_q  <= SYM_J;
      ones_q <= '0;
    end else if (sample_i) begin
      ref_q <= sym_i;
      if (!same)                 ones_q <= '0;
      else if (ones_q != ONES_MAX) ones_q <= ones_q + 1'b1;
    end
  end
endmodule

// File: rtl/usb_line_rx.sv
module usb_line_rx
  import usb_line_pkg::*;
#(
  parameter int CPB_FS    = 4,
  parameter int CPB_LS    = 32,
  parameter int STUFF_RUN = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic       low_speed_i,
  output logic [1:0] sym_o,
  output logic       sop_o,
  output logic       bit_valid_o,
  output logic       bit_o,
  output logic       stuff_o,
  output logic       eop_o,
  output logic       err_o
);
  line_sym_e sym_now, prev_line_q, last_q;
  rx_state_e state_q;
  logic      tick, sop_det, eop_det, err_det, data_tick, dec_clear;
  logic      dv, db, ds;

  usb_sym_decode u_sym (
    .dp_i        (dp_i),
    .dm_i        (dm_i),
    .low_speed_i (low_speed_i),
    .sym_o       (sym_now)
  );

  assign sop_det = (state_q == ST_IDLE) && (prev_line_q == SYM_J) && (sym_now == SYM_K);

  usb_bit_timer #(.CPB_FS(CPB_FS), .CPB_LS(CPB_LS)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .low_speed_i (low_speed_i),
    .start_i     (sop_det),
    .run_i       (state_q != ST_IDLE),
    .tick_o      (tick)
  );

  assign data_tick = tick && (state_q == ST_BITS) && (sym_now == SYM_J || sym_now == SYM_K);
  assign err_det   = tick && (state_q == ST_BITS) && (sym_now == SYM_SE1);
  assign eop_det   = tick && (state_q == ST_EOP) && (sym_now == SYM_J) && (last_q == SYM_SE0);
  assign dec_clear = sop_det || eop_det || err_det;

  usb_nrzi_destuff #(.STUFF_RUN(STUFF_RUN)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (dec_clear),
    .sample_i   (data_tick),
    .sym_i      (sym_now),
    .data_vld_o (dv),
    .data_o     (db),
    .stuff_o    (ds)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      prev_line_q <= SYM_J;
      last_q      <= SYM_J;
    end else begin
      prev_line_q <= sym_now;
      unique case (state_q)
        ST_IDLE: if (sop_det) state_q <= ST_BITS;
        ST_BITS: if (tick) begin
          if (sym_now == SYM_SE0) begin
            state_q <= ST_EOP;
            last_q  <= SYM_SE0;
          end else if (sym_now == SYM_SE1) begin
            state_q <= ST_IDLE;
          end
        end
        ST_EOP: if (tick) begin
          if (eop_det) begin
            state_q <= ST_IDLE;
            last_q  <= SYM_J;
          end else begin
            last_q <= sym_now;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sop_o       <= 1'b0;
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b0;
      stuff_o     <= 1'b0;
      eop_o       <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      sop_o       <= sop_det;
      bit_valid_o <= dv;
      bit_o       <= dv && db;
      stuff_o     <= ds;
      eop_o       <= eop_det;
      err_o       <= err_det;
    end
  end

  assign sym_o = sym_now;
endmodule

// File: rtl/usb_line_rx_chk.sv
module usb_line_rx_chk #(
  parameter int CPB_FS    = 4,
  parameter int CPB_LS    = 32,
  parameter int STUFF_RUN = 6
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       low_speed_i,
  input logic [1:0] sym_o,
  input logic       sop_o,
  input logic       bit_valid_o,
  input logic       bit_o,
  input logic       stuff_o,
  input logic       eop_o,
  input logic       err_o
);
  localparam int CPB_MAX = (CPB_LS > CPB_FS) ? CPB_LS : CPB_FS;
  localparam int GAP_W   = $clog2(CPB_MAX) + 2;
  localparam int ONES_W  = $clog2(STUFF_RUN + 2);

  logic [GAP_W-1:0]  gap_q, exp_gap;
  logic [ONES_W-1:0] ones_q;
  logic              first_q, in_pkt_q, ev;

  assign ev = bit_valid_o || stuff_o;
  always_comb begin
    if (low_speed_i) exp_gap = first_q ? GAP_W'(CPB_LS / 2) : GAP_W'(CPB_LS);
    else             exp_gap = first_q ? GAP_W'(CPB_FS / 2) : GAP_W'(CPB_FS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q    <= '0;
      first_q  <= 1'b0;
      in_pkt_q <= 1'b0;
      ones_q   <= '0;
    end else begin
      if (sop_o || ev)        gap_q <= GAP_W'(1);
      else if (~&gap_q)       gap_q <= gap_q + 1'b1;
      if (sop_o)              first_q <= 1'b1;
      else if (ev)            first_q <= 1'b0;
      if (sop_o)              in_pkt_q <= 1'b1;
      else if (eop_o || err_o) in_pkt_q <= 1'b0;
      if (sop_o || stuff_o || (bit_valid_o && !bit_o)) ones_q <= '0;
      else if (bit_valid_o && bit_o && ~&ones_q)        ones_q <= ones_q + 1'b1;
    end
  end

  p_strobe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sop_o, bit_valid_o, stuff_o, eop_o, err_o}));

  p_sop_on_k_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> ($past(sym_o) == 2'b10));

  p_grid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev |-> (gap_q == exp_gap));

  p_stuff_six_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_o |-> (ones_q == ONES_W'(STUFF_RUN)));

  p_zero_not_stuff_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && !bit_o) |-> (ones_q != ONES_W'(STUFF_RUN)));

  p_quiet_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev || eop_o || err_o) |-> in_pkt_q);

  p_single_close_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_o || err_o) |=> !(eop_o || err_o || ev));
endmodule

bind usb_line_rx usb_line_rx_chk #(
  .CPB_FS(CPB_FS), .CPB_LS(CPB_LS), .STUFF_RUN(STUFF_RUN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .low_speed_i (low_speed_i),
  .sym_o       (sym_o),
  .sop_o       (sop_o),
  .bit_valid_o (bit_valid_o),
  .bit_o       (bit_o),
  .stuff_o     (stuff_o),
  .eop_o       (eop_o),
  .err_o       (err_o)
);

// File: tb/usb_line_rx_test.sv
module usb_line_rx_test;
  localparam int CPB_FS = 4;
  localparam int CPB_LS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b1, dm = 1'b0, ls = 1'b0;
  logic [1:0] sym;
  logic sop, bv, bo, stf, eop, err;

  int checks = 0, errors = 0;
  int cyc = 0, n_bits = 0, n_stuff = 0, n_sop = 0, n_eop = 0, n_err = 0;
  int last_ev = 0, first_gap = 0, space_err = 0, cur_cpb = CPB_FS;
  bit pend = 1'b0;
  bit got [0:255];

  always #4 clk = ~clk;

  usb_line_rx #(.CPB_FS(CPB_FS), .CPB_LS(CPB_LS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm), .low_speed_i(ls),
    .sym_o(sym), .sop_o(sop), .bit_valid_o(bv), .bit_o(bo),
    .stuff_o(stf), .eop_o(eop), .err_o(err)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (sop) begin
        n_sop <= n_sop + 1; pend <= 1'b1; last_ev <= cyc;
      end
      if (bv || stf) begin
        if (pend) begin first_gap <= cyc - last_ev; pend <= 1'b0; end
        else if (cyc - last_ev != cur_cpb) space_err <= space_err + 1;
        last_ev <= cyc;
      end
      if (bv) begin got[n_bits % 256] <= bo; n_bits <= n_bits + 1; end
      if (stf) n_stuff <= n_stuff + 1;
      if (eop) n_eop <= n_eop + 1;
      if (err) n_err <= n_err + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 SE0, 1 J, 2 K, 3 SE1
  task automatic put_line(input int s);
    case (s)
      0: begin dp = 1'b0; dm = 1'b0; end
      3: begin dp = 1'b1; dm = 1'b1; end
      1: begin dp = ~ls; dm = ls; end
      default: begin dp = ls; dm = ~ls; end
    endcase
  endtask

  task automatic hold(input int s, input int n);
    put_line(s);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_packet(input bit lsel, input logic [63:0] data, input int nd, input bit se1);
    bit exp [0:127];
    int nexp = 0, nst = 0, ones = 0, cpb, ofs;
    int b0, s0, p0, e0, r0, sp0;
    bit lvl_j = 1'b1;
    bit b;
    hold(0, 2);
    ls = lsel;
    cpb = lsel ? CPB_LS : CPB_FS;
    cur_cpb = cpb;
    hold(1, 2 * cpb);
    b0 = n_bits; s0 = n_stuff; p0 = n_sop; e0 = n_eop; r0 = n_err; sp0 = space_err;
    for (int i = 0; i < 8 + nd; i++) begin
      b = (i < 8) ? (i == 7) : data[i-8];
      exp[nexp] = b; nexp++;
      if (!b) lvl_j = ~lvl_j;
      hold(lvl_j ? 1 : 2, cpb);
      if (b) ones++; else ones = 0;
      if (ones == 6) begin
        lvl_j = ~lvl_j; nst++; ones = 0;
        hold(lvl_j ? 1 : 2, cpb);
      end
    end
    if (se1) begin
      hold(3, cpb);
      hold(1, 3 * cpb);
    end else begin
      hold(0, 2 * cpb);
      hold(1, 3 * cpb);
    end
    check(n_sop - p0 == 1, "R3 sop count", n_sop - p0, 1);
    check(n_bits - b0 == nexp, "R7 data bit count", n_bits - b0, nexp);
    ofs = 0;
    for (int i = 0; i < nexp; i++) if (got[(b0 + i) % 256] != exp[i]) ofs++;
    check(ofs == 0, "R5 decoded bit mismatches", ofs, 0);
    check(n_stuff - s0 == nst, "R6 stuff count", n_stuff - s0, nst);
    check(first_gap == cpb / 2, "R4 first sample offset", first_gap, cpb / 2);
    check(space_err == sp0, "R4 bit spacing errors", space_err - sp0, 0);
    if (se1) begin
      check(n_err - r0 == 1, "R9 err count", n_err - r0, 1);
      check(n_eop - e0 == 0, "R9 no eop", n_eop - e0, 0);
    end else begin
      check(n_eop - e0 == 1, "R8 eop count", n_eop - e0, 1);
      check(n_err - r0 == 0, "R8 no err", n_err - r0, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({sop, bv, bo, stf, eop, err} == 6'b0, "R10 reset outputs", int'({sop, bv, bo, stf, eop, err}), 0);
    // line classification, checked under reset so no packet starts
    for (int sp = 0; sp < 2; sp++) begin
      for (int pv = 0; pv < 4; pv++) begin
        int e;
        ls = sp[0]; dp = pv[1]; dm = pv[0];
        #1;
        if (dp == dm) e = dp ? 3 : 0;
        else e = ((sp == 1) ? dm : dp) ? 1 : 2;
        check(int'(sym) == e, sp ? "R2 low-speed symbol" : "R1 full-speed symbol", int'(sym), e);
        @(negedge clk);
      end
    end
    ls = 1'b0; dp = 1'b1; dm = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    hold(1, 40);
    hold(0, 20);
    hold(1, 20);
    check(n_sop + n_bits + n_stuff + n_eop + n_err == 0, "R11 idle quiet",
          n_sop + n_bits + n_stuff + n_eop + n_err, 0);
    for (int v = 0; v < 256; v++) send_packet(1'b0, 64'(v), 8, 1'b0);
    for (int v = 0; v < 16; v++) send_packet(1'b1, 64'(v * 17), 8, 1'b0);
    send_packet(1'b0, {64{1'b1}}, 40, 1'b0);
    send_packet(1'b1, {64{1'b1}}, 40, 1'b0);
    send_packet(1'b0, 64'h0000_0000_00F0_7F3F, 24, 1'b0);
    send_packet(1'b0, 64'h0000_0000_0000_00A5, 8, 1'b1);
    send_packet(1'b1, 64'h0000_0000_0000_003C, 8, 1'b1);
    send_packet(1'b0, 64'h0000_0000_0000_7E7E, 16, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule